// File: doc/BRIEF.md
# Palette DAC Write Port

This block holds a 256-entry colour lookup table of 24-bit RGB values and gives a host a byte-wide, register-mapped way to load it. The host first writes an entry number to the index register. It then writes colour bytes one after another to the colour data register. Each byte lands in the red, green or blue slot of the entry being pointed at. After blue, the pointer moves to the next entry by itself, so a whole table can be streamed after a single index write.

Whenever a written byte differs from the byte already stored in that slot, the block raises a one-cycle redraw pulse, so the display pipeline repaints only when the visible colours really change. Components are kept at their full 8-bit width.

A second, independent port serves the scan-out path. It takes a pixel value as a table address and returns that entry's 24-bit colour one clock later. The host can read the index register back; colour data cannot be read back through the host port.

Top module: `pal_dac_wport`

## Requirements
- R1: While rst_n is low at a rising clock edge, the index and the component position are cleared to 0, every palette entry is cleared to 0x000000, and redraw_pulse, host_rdata and look_rgb are 0 after that edge.
- R2: A host write at window offset 0x08 loads host_wdata into the entry index and returns the component position to red (position 0).
- R3: A host write at window offset 0x09 stores all 8 bits of host_wdata into the current component of the current entry. Position 0 is red (look_rgb[23:16]), 1 is green (look_rgb[15:8]) and 2 is blue (look_rgb[7:0]).
- R4: Each colour data write advances the position 0 -> 1 -> 2. A write at position 2 returns it to 0 and increments the entry index.
- R5: On that increment the entry index wraps from 255 to 0.
- R6: redraw_pulse is high for exactly the one cycle after a colour data write whose byte differs from the stored byte. It stays low after a write of an equal byte and after any other access.
- R7: A host read at offset 0x08 returns the current entry index on host_rdata in the following cycle. A read of any other offset, or no read, gives 0 there.
- R8: Host writes to any window offset other than 0x08 and 0x09 change neither the index, the component position nor the palette.
- R9: look_rgb shows, one cycle after look_idx is presented, the entry as it stood before that clock edge. A colour write in the same cycle becomes visible on the next lookup.
- R10: An index write made part-way through an entry abandons the rest of that entry. The next colour byte goes to the red slot of the newly loaded entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Byte offset inside the 32-byte register window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after host_rd |
| look_idx | input | 8 | Pixel value used as table address by display logic |
| look_rgb | output | 24 | Colour of the addressed entry, one cycle later |
| redraw_pulse | output | 1 | One-cycle request to repaint the screen |

## Verification
The hardest situations to reach are the pointer wrap from entry 255 to entry 0 in the middle of a stream, and a colour write that lands on the very entry being looked up in the same cycle. The stimulus reaches the first by loading index 255 and streaming past it. It reaches the second by holding look_idx on the entry being written and comparing the old and new colour on consecutive cycles. A full 768-byte fill followed by a mid-run reset then shows that every entry, not just the touched ones, returns to zero. A cycle-accurate behavioural model in the bench predicts all three outputs on every clock.

// File: rtl/pal_dac_pkg.sv
// Package: pal_dac_pkg
// Shared sizes and register offsets for the palette write port.
// Assumes the window base is decoded outside; offsets are window-relative.
package pal_dac_pkg;
    localparam int DATA_W      = 8;   // host bus width
    localparam int IDX_W       = 8;   // entry index width
    localparam int COMP_W      = 8;   // bits per colour component
    localparam int NUM_COMP    = 3;   // red, green, blue
    localparam int WIN_ADDR_W  = 5;   // 32-byte window
    localparam int RGB_W       = NUM_COMP * COMP_W;
    localparam int SUB_W       = $clog2(NUM_COMP);

    localparam logic [WIN_ADDR_W-1:0] OFS_INDEX = 5'h08;
    localparam logic [WIN_ADDR_W-1:0] OFS_COLOR = 5'h09;

    // Decoded host access kinds
    typedef struct packed {
        logic idx_wr;
        logic data_wr;
        logic idx_rd;
    } host_op_t;
endpackage

// File: rtl/pal_dac_hostif.sv
// Module: pal_dac_hostif
// Decodes host accesses in the register window into index-write,
// colour-write and index-read strobes, and registers the read data.
// Assumes at most one access offset per cycle; unknown offsets do nothing.
module pal_dac_hostif
    import pal_dac_pkg::*;
#(
    parameter int ADDR_W = WIN_ADDR_W,
    parameter int DW     = DATA_W,
    parameter int IW     = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [IW-1:0]     cur_idx,
    output host_op_t          op,
    output logic [DW-1:0]     host_rdata
);
    logic [DW-1:0] rdata_q;

    // Decode the window offset into access strobes.
    always_comb begin
        op.idx_wr  = host_wr && (host_addr == OFS_INDEX);
        op.data_wr = host_wr && (host_addr == OFS_COLOR);
        op.idx_rd  = host_rd && (host_addr == OFS_INDEX);
    end

    // Register the read-back value of the index register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (op.idx_rd)
            rdata_q <= DW'(cur_idx);
        else
            rdata_q <= '0;
    end

    assign host_rdata = rdata_q;

    // Index and colour writes never decode from one access.
    assert_decode_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(op.idx_wr && op.data_wr));
endmodule

// File: rtl/pal_dac_ptr.sv
// Module: pal_dac_ptr
// Holds the entry index and component position, and turns a colour
// write into a one-hot write enable for the component banks.
// Assumes IW <= DW so an index write takes the low host data bits.
module pal_dac_ptr
    import pal_dac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W,
    parameter int NC = NUM_COMP,
    parameter int SW = SUB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    output logic [IW-1:0] idx_q,
    output logic [SW-1:0] sub_q,
    output logic [NC-1:0] comp_we
);
    localparam logic [SW-1:0] LAST_SUB = SW'(NC - 1);

    // Load, advance or wrap the entry pointer and component position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            sub_q <= '0;
        end else if (idx_wr) begin
            idx_q <= wdata[IW-1:0];
            sub_q <= '0;
        end else if (data_wr) begin
            if (sub_q == LAST_SUB) begin
                sub_q <= '0;
                idx_q <= idx_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    // One write enable per component bank.
    for (genvar g = 0; g < NC; g++) begin : g_we
        assign comp_we[g] = data_wr && (sub_q == SW'(g));
    end

    // Position never leaves the component range.
    assert_sub_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q <= LAST_SUB);

    // An index write loads the pointer and restarts at red.
    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_q == $past(wdata[IW-1:0])) && (sub_q == '0));

    // A write at the last component moves to the next entry.
    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !idx_wr && sub_q == LAST_SUB)
            |=> (sub_q == '0) && (idx_q == $past(idx_q) + 1'b1));

    // Without a host write the pointer holds.
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && !data_wr) |=> $stable(idx_q) && $stable(sub_q));
endmodule

// File: rtl/pal_dac_bank.sv
// Module: pal_dac_bank
// One colour component of the palette: a resettable array of entries with
// a write port that flags value changes and a registered lookup port.
// Assumes lookups read the pre-edge contents (read before write).
module pal_dac_bank
    import pal_dac_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int CW = COMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          changed,
    input  logic [IW-1:0] rd_addr,
    output logic [CW-1:0] rd_data
);
    localparam int DEPTH = 1 << IW;

    logic [CW-1:0] mem [DEPTH];
    logic [CW-1:0] rd_q;

    // Store writes; reset clears every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++)
                mem[e] <= '0;
        end else if (we) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered lookup for the display path.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= mem[rd_addr];
    end

    // A write counts as a change only when the byte differs.
    assign changed = we && (mem[wr_addr] != wr_data);
    assign rd_data = rd_q;
endmodule

// File: rtl/pal_dac_wport.sv
// Module: pal_dac_wport
// Top of the palette write port: host decode, pointer, three component
// banks and the redraw pulse register.
// Assumes the host window base is already decoded to host_addr.
module pal_dac_wport
    import pal_dac_pkg::*;
#(
    parameter int ADDR_W = WIN_ADDR_W,
    parameter int DW     = DATA_W,
    parameter int IW     = IDX_W,
    parameter int CW     = COMP_W,
    parameter int NC     = NUM_COMP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic [IW-1:0]     look_idx,
    output logic [NC*CW-1:0]  look_rgb,
    output logic              redraw_pulse
);
    localparam int SW = (NC > 1) ? $clog2(NC) : 1;

    host_op_t      op;
    logic [IW-1:0] idx_q;
    logic [SW-1:0] sub_q;
    logic [NC-1:0] comp_we;
    logic [NC-1:0] comp_changed;
    logic          redraw_q;

    pal_dac_hostif #(.ADDR_W(ADDR_W), .DW(DW), .IW(IW)) u_hostif (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .cur_idx    (idx_q),
        .op         (op),
        .host_rdata (host_rdata)
    );

    pal_dac_ptr #(.DW(DW), .IW(IW), .NC(NC), .SW(SW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (op.idx_wr),
        .data_wr (op.data_wr),
        .wdata   (host_wdata),
        .idx_q   (idx_q),
        .sub_q   (sub_q),
        .comp_we (comp_we)
    );

    // Component 0 (red) sits in the top byte of the RGB word.
    for (genvar g = 0; g < NC; g++) begin : g_bank
        pal_dac_bank #(.IW(IW), .CW(CW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (comp_we[g]),
            .wr_addr (idx_q),
            .wr_data (host_wdata[CW-1:0]),
            .changed (comp_changed[g]),
            .rd_addr (look_idx),
            .rd_data (look_rgb[(NC-1-g)*CW +: CW])
        );
    end

    // Turn any changed component into a single-cycle redraw request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            redraw_q <= 1'b0;
        else
            redraw_q <= |comp_changed;
    end

    assign redraw_pulse = redraw_q;

    // At most one component bank is written per cycle.
    assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(comp_we));

    // A redraw request always follows a colour data write.
    assert_redraw_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redraw_pulse |-> $past(host_wr && host_addr == OFS_COLOR));

    // Index writes and idle cycles never request a redraw.
    assert_no_redraw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == OFS_COLOR) |=> !redraw_pulse);
endmodule

// File: tb/pal_dac_wport_tb.sv
// Bench: pal_dac_wport_tb_top
// Behavioural reference model of the palette port, compared on every clock.
module pal_dac_wport_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  look_idx = '0;
    logic [23:0] look_rgb;
    logic        redraw_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference state
    int pal [256][3];
    int m_idx = 0;
    int m_sub = 0;

    always #10 clk = ~clk;

    pal_dac_wport dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .look_idx     (look_idx),
        .look_rgb     (look_rgb),
        .redraw_pulse (redraw_pulse)
    );

    function automatic int entry_rgb(int e);
        return (pal[e][0] << 16) | (pal[e][1] << 8) | pal[e][2];
    endfunction

    // One clock: drive, predict, advance the model, sample at the falling edge.
    task automatic cyc(string tag, bit rst, bit wr, bit rd, int addr, int wd, int li);
        int e_rgb;
        int e_rd;
        bit e_rdw;
        rst_n = rst; host_wr = wr; host_rd = rd;
        host_addr = 5'(addr); host_wdata = 8'(wd); look_idx = 8'(li);
        if (!rst) begin
            e_rgb = 0; e_rd = 0; e_rdw = 0;
            for (int e = 0; e < 256; e++)
                for (int c = 0; c < 3; c++) pal[e][c] = 0;
            m_idx = 0; m_sub = 0;
        end else begin
            e_rgb = entry_rgb(li);
            e_rd  = (rd && addr == 8) ? m_idx : 0;
            e_rdw = wr && addr == 9 && pal[m_idx][m_sub] != wd;
            if (wr && addr == 8) begin
                m_idx = wd; m_sub = 0;
            end else if (wr && addr == 9) begin
                pal[m_idx][m_sub] = wd;
                if (m_sub == 2) begin
                    m_sub = 0; m_idx = (m_idx + 1) % 256;
                end else m_sub++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (look_rgb !== 24'(e_rgb) || host_rdata !== 8'(e_rd) || redraw_pulse !== e_rdw) begin
            errors++;
            $display("FAIL %s: rgb=%06h rdata=%02h redraw=%b, expected rgb=%06h rdata=%02h redraw=%b",
                     tag, look_rgb, host_rdata, redraw_pulse, e_rgb[23:0], e_rd[7:0], e_rdw);
        end
    endtask

    task automatic hwr(string tag, int addr, int wd, int li);
        cyc(tag, 1, 1, 0, addr, wd, li);
    endtask

    task automatic hrd(string tag, int li);
        cyc(tag, 1, 0, 1, 8, 0, li);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) cyc("R1", 0, 0, 0, 0, 0, 0);
        hrd("R1", 0);
        hrd("R1", 255);
        // R2: load index, R7 read back
        hwr("R2", 8, 10, 0);
        hrd("R7", 0);
        // R3/R6: stream one entry
        hwr("R3", 9, 8'h11, 10);
        hwr("R3", 9, 8'h22, 10);
        hwr("R3", 9, 8'h83, 10);
        hrd("R4", 10);
        cyc("R3", 1, 0, 0, 0, 0, 10);
        // R6: equal byte gives no redraw, changed byte does
        hwr("R6", 8, 10, 10);
        hwr("R6", 9, 8'h11, 10);
        hwr("R6", 9, 8'hFF, 10);
        // R10: index write mid-entry
        hwr("R10", 8, 20, 10);
        hwr("R10", 9, 8'hAB, 20);
        hrd("R10", 20);
        cyc("R10", 1, 0, 0, 0, 0, 20);
        // R5: wrap 255 -> 0
        hwr("R5", 8, 255, 255);
        hwr("R5", 9, 1, 255);
        hwr("R5", 9, 2, 255);
        hwr("R5", 9, 3, 255);
        hrd("R5", 255);
        hwr("R5", 9, 8'h44, 0);
        cyc("R5", 1, 0, 0, 0, 0, 0);
        // R8: other offsets ignored
        hwr("R8", 5'h0A, 8'h55, 0);
        hwr("R8", 5'h00, 8'h66, 0);
        hwr("R8", 5'h1F, 8'h77, 0);
        hwr("R8", 5'h09, 8'h99, 0);
        hrd("R8", 0);
        cyc("R7", 1, 0, 1, 5'h0E, 0, 0);
        // R9: same-cycle write and lookup of one entry
        hwr("R9", 8, 5, 5);
        hwr("R9", 9, 8'hC3, 5);
        cyc("R9", 1, 0, 0, 0, 0, 5);
        // Full fill with lookups riding along
        hwr("R4", 8, 0, 0);
        for (int e = 0; e < 256; e++)
            for (int c = 0; c < 3; c++)
                hwr("R4", 9, (e * 7 + c * 53 + 1) % 256, (e * 13) % 256);
        for (int e = 0; e < 256; e++)
            cyc("R9", 1, 0, 0, 0, 0, e);
        // R1: reset mid-run clears every entry
        cyc("R1", 0, 0, 0, 0, 0, 0);
        for (int e = 0; e < 256; e++)
            hrd("R1", e);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule